// File: doc/BRIEF.md
# Flash Erase Block Selector

This block holds the selection of the one flash block that may be erased next. Software writes a one-hot pattern into two 8-bit registers on a simple synchronous register bus. The low register covers blocks 0 to 7 and the high register covers blocks 8 and up. The block presents the pair as a single 14-bit erase-select vector to the flash controller. Every block whose select bit is clear is protected from erase.

Several hardware conditions force the selection back to empty: reset, the two standby states, a low level on the flash write-enable pin, and a clear software write-enable bit. The last of these acts on the two registers in different ways. A write that would leave more than one block selected across both registers empties both registers instead. Bits of the high register that the chosen size does not implement always read as zero. While on-chip flash is disabled, the registers cannot be reached from the bus and the select vector reads as empty.

Top module: `erase_sel_regs`

## Requirements
- R1: After a synchronous active-low reset, both registers read 0x00 and `erase_sel` is all zeros.
- R2: While `hw_stby`, `sw_stby` is high or `fwe_pin` is low, both registers load 0x00 on each clock edge. This takes priority over a bus write in the same cycle, and the write is lost.
- R3: While `fwe_pin` is high and `swe_bit` is low, the low register is held at 0x00 and bit 0 of the high register is held at 0. The other bits of the high register can still be written and keep their value.
- R4: A write with `bus_we` high replaces the whole register at address 0 (low, blocks 0–7) or address 1 (high, blocks 8 and up) on the next clock edge. `bus_rdata` returns the addressed register combinationally. `erase_sel[i]` is the select bit of block i, with the high register placed above the low one.
- R5: If the pair would hold two or more set bits after a write, counted across both registers, then both registers load 0x00 instead. This also applies to two bits within one write.
- R6: While `flash_en` is low, `bus_rdata` and `erase_sel` are zero and writes have no effect. The stored selection reappears when `flash_en` returns high.
- R7: With NUM_BLOCKS = 14, write data to high-register bits 7:6 is dropped. With NUM_BLOCKS = 12, bits 7:4 are dropped. Dropping happens before the R5 count, and dropped bits read as 0.
- R8: Writes to any address other than 0 or 1 change nothing, and reads from such addresses return 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| hw_stby | input | 1 | Hardware standby active |
| sw_stby | input | 1 | Software standby active |
| fwe_pin | input | 1 | Level of the flash write-enable pin |
| swe_bit | input | 1 | Software write-enable bit |
| flash_en | input | 1 | On-chip flash enabled |
| bus_addr | input | ADDR_W | Register address (0 low, 1 high) |
| bus_we | input | 1 | Write strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data of the addressed register |
| erase_sel | output | 14 | One-hot erase select, block i on bit i |

## Verification
The bench targets the cases where the two registers interact. A bit is set in one register and then another bit is written into the other register. A design that checked each register on its own would end up with two blocks selected rather than an empty selection. The partial clear from the software enable is driven while writes continue to the high register. A design that cleared the whole high register would lose block 11, and one that left bit 0 alone would keep block 8 selected. Standby and the pin going low are asserted in the same cycle as a write, so a design that let the write win would show the written block. A 12-block instance runs beside the 14-block one. The pattern 0x18 selects block 11 on the 12-block instance but empties the 14-block instance, which shows whether reserved bits are dropped before or after the one-hot count.

// File: rtl/esr_pkg.sv
// Package: shared widths, the register-pair type and the valid-bit mask
// function for the erase block selector.
// Assumes the high register never implements more than 6 blocks.
package esr_pkg;
    localparam int REG_W      = 8;
    localparam int MAX_BLOCKS = 14;
    localparam int HI_OUT_W   = MAX_BLOCKS - REG_W;

    typedef struct packed {
        logic [REG_W-1:0] hi;
        logic [REG_W-1:0] lo;
    } esr_pair_t;

    // Mask of implemented high-register bits for a given block count.
    function automatic logic [REG_W-1:0] hi_valid_mask(input int nblk);
        logic [REG_W-1:0] m;
        for (int i = 0; i < REG_W; i++) begin
            m[i] = (i < (nblk - REG_W));
        end
        return m;
    endfunction
endpackage

// File: rtl/esr_write_decode.sv
// Module: esr_write_decode
// Turns a bus write into per-register write strobes and data. Reserved
// high-register bits are dropped here. No strobe is raised while flash is
// disabled or when the address is unmapped.
// Assumes LO_ADDR and HI_ADDR differ.
module esr_write_decode
    import esr_pkg::*;
#(
    parameter int ADDR_W     = 4,
    parameter int LO_ADDR    = 0,
    parameter int HI_ADDR    = 1,
    parameter int NUM_BLOCKS = 14
) (
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_we,
    input  logic [REG_W-1:0]  bus_wdata,
    input  logic              flash_en,
    output logic              wr_lo,
    output logic              wr_hi,
    output logic [REG_W-1:0]  lo_data,
    output logic [REG_W-1:0]  hi_data
);
    localparam logic [REG_W-1:0]  HI_MASK = hi_valid_mask(NUM_BLOCKS);
    localparam logic [ADDR_W-1:0] LO_A    = ADDR_W'(LO_ADDR);
    localparam logic [ADDR_W-1:0] HI_A    = ADDR_W'(HI_ADDR);

    // Purpose: address decode gated by the write strobe and flash enable.
    always_comb begin
        wr_lo = bus_we && flash_en && (bus_addr == LO_A);
        wr_hi = bus_we && flash_en && (bus_addr == HI_A);
    end

    // Purpose: data per register, with the high register masked to its valid bits.
    always_comb begin
        lo_data = bus_wdata;
        hi_data = bus_wdata & HI_MASK;
    end
endmodule

// File: rtl/esr_next_state.sv
// Module: esr_next_state
// Works out the next register pair. It applies the pending write, then the
// software-enable partial clear, then the at-most-one-bit rule. The hard
// clear overrides all of these.
// Assumes the write data is already masked.
module esr_next_state
    import esr_pkg::*;
(
    input  esr_pair_t        cur,
    input  logic             wr_lo,
    input  logic             wr_hi,
    input  logic [REG_W-1:0] lo_data,
    input  logic [REG_W-1:0] hi_data,
    input  logic             hard_clr,
    input  logic             soft_clr,
    output esr_pair_t        nxt,
    output logic             multi_hit
);
    esr_pair_t cand;

    // Purpose: the candidate value after the write and the partial clear.
    always_comb begin
        cand = cur;
        if (wr_lo) cand.lo = lo_data;
        if (wr_hi) cand.hi = hi_data;
        if (soft_clr) begin
            cand.lo    = '0;
            cand.hi[0] = 1'b0;
        end
    end

    // Purpose: the one-hot rule and the hard-clear priority.
    always_comb begin
        multi_hit = !hard_clr && ($countones(cand) > 1);
        if (hard_clr || multi_hit) nxt = '0;
        else                       nxt = cand;
    end
endmodule

// File: rtl/esr_reg_bank.sv
// Module: esr_reg_bank
// Storage for the low and high select registers.
// Assumes the next value already obeys every clear and masking rule.
module esr_reg_bank
    import esr_pkg::*;
#(
    parameter int NUM_BLOCKS = 14
) (
    input  logic      clk,
    input  logic      rst_n,
    input  esr_pair_t nxt,
    output esr_pair_t q
);
    localparam logic [REG_W-1:0] HI_MASK = hi_valid_mask(NUM_BLOCKS);

    // Purpose: flops for the pair, cleared by the synchronous reset.
    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= nxt;
    end

    // R5
    sel_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(q));

    // R7
    rsvd_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (q.hi & ~HI_MASK) == '0);
endmodule

// File: rtl/erase_sel_regs.sv
// Module: erase_sel_regs (top)
// Two bus registers that choose the single flash block open for erase.
// Drives the 14-bit one-hot select, which is blanked while flash is disabled.
// Assumes the bus is synchronous to clk and that reads have no side effects.
module erase_sel_regs
    import esr_pkg::*;
#(
    parameter int ADDR_W     = 4,
    parameter int LO_ADDR    = 0,
    parameter int HI_ADDR    = 1,
    parameter int NUM_BLOCKS = 14
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  hw_stby,
    input  logic                  sw_stby,
    input  logic                  fwe_pin,
    input  logic                  swe_bit,
    input  logic                  flash_en,
    input  logic [ADDR_W-1:0]     bus_addr,
    input  logic                  bus_we,
    input  logic [REG_W-1:0]      bus_wdata,
    output logic [REG_W-1:0]      bus_rdata,
    output logic [MAX_BLOCKS-1:0] erase_sel
);
    localparam logic [ADDR_W-1:0] LO_A = ADDR_W'(LO_ADDR);
    localparam logic [ADDR_W-1:0] HI_A = ADDR_W'(HI_ADDR);

    logic             wr_lo, wr_hi, hard_clr, soft_clr, multi_hit;
    logic [REG_W-1:0] lo_data, hi_data;
    esr_pair_t        q, nxt;

    // Purpose: decode the clear conditions from the mode inputs.
    always_comb begin
        hard_clr = hw_stby || sw_stby || !fwe_pin;
        soft_clr = fwe_pin && !swe_bit;
    end

    esr_write_decode #(
        .ADDR_W(ADDR_W), .LO_ADDR(LO_ADDR), .HI_ADDR(HI_ADDR), .NUM_BLOCKS(NUM_BLOCKS)
    ) u_dec (
        .bus_addr(bus_addr), .bus_we(bus_we), .bus_wdata(bus_wdata),
        .flash_en(flash_en), .wr_lo(wr_lo), .wr_hi(wr_hi),
        .lo_data(lo_data), .hi_data(hi_data)
    );

    esr_next_state u_next (
        .cur(q), .wr_lo(wr_lo), .wr_hi(wr_hi), .lo_data(lo_data), .hi_data(hi_data),
        .hard_clr(hard_clr), .soft_clr(soft_clr), .nxt(nxt), .multi_hit(multi_hit)
    );

    esr_reg_bank #(.NUM_BLOCKS(NUM_BLOCKS)) u_bank (
        .clk(clk), .rst_n(rst_n), .nxt(nxt), .q(q)
    );

    // Purpose: read mux, returning zero for unmapped addresses or disabled flash.
    always_comb begin
        bus_rdata = '0;
        if (flash_en) begin
            if (bus_addr == LO_A)      bus_rdata = q.lo;
            else if (bus_addr == HI_A) bus_rdata = q.hi;
        end
    end

    // Purpose: the select vector, high register above low, blanked when flash is off.
    always_comb begin
        erase_sel = flash_en ? {q.hi[HI_OUT_W-1:0], q.lo} : '0;
    end

    // R2
    hard_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (hw_stby || sw_stby || !fwe_pin) |=> (q == '0));

    // R3
    soft_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fwe_pin && !swe_bit) |=> (q.lo == '0 && !q.hi[0]));

    // R5
    multi_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        multi_hit |=> (q == '0));

    // R6
    off_write_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!flash_en && fwe_pin && swe_bit && !hw_stby && !sw_stby) |=> $stable(q));

    // R8
    unmapped_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && bus_addr != LO_A && bus_addr != HI_A && fwe_pin && swe_bit
         && !hw_stby && !sw_stby) |=> $stable(q));
endmodule

// File: tb/erase_sel_regs_tb.sv
module erase_sel_regs_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        hw_stby = 1'b0, sw_stby = 1'b0, fwe_pin = 1'b1, swe_bit = 1'b1, flash_en = 1'b1;
    logic [3:0]  bus_addr = '0;
    logic        bus_we = 1'b0;
    logic [7:0]  bus_wdata = '0;
    logic [7:0]  rdata, rdata12;
    logic [13:0] sel, sel12;
    int          n_chk = 0, n_bad = 0;
    bit          done = 1'b0;

    always #2 clk = ~clk;   // 250 MHz

    erase_sel_regs #(.NUM_BLOCKS(14)) u_dut (
        .clk(clk), .rst_n(rst_n), .hw_stby(hw_stby), .sw_stby(sw_stby),
        .fwe_pin(fwe_pin), .swe_bit(swe_bit), .flash_en(flash_en),
        .bus_addr(bus_addr), .bus_we(bus_we), .bus_wdata(bus_wdata),
        .bus_rdata(rdata), .erase_sel(sel));

    erase_sel_regs #(.NUM_BLOCKS(12)) u_dut12 (
        .clk(clk), .rst_n(rst_n), .hw_stby(hw_stby), .sw_stby(sw_stby),
        .fwe_pin(fwe_pin), .swe_bit(swe_bit), .flash_en(flash_en),
        .bus_addr(bus_addr), .bus_we(bus_we), .bus_wdata(bus_wdata),
        .bus_rdata(rdata12), .erase_sel(sel12));

    task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
        end
    endtask

    // Write; returns at the falling edge after the update edge.
    task automatic wr(input logic [3:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_addr = a; bus_we = 1'b1; bus_wdata = d;
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic rd(input logic [3:0] a);
        bus_addr = a;
        #1;
    endtask

    task automatic t_reset;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 sel", 16'(sel), 16'h0);
        rd(4'd0); chk("R1 lo read", 16'(rdata), 16'h0);
        rd(4'd1); chk("R1 hi read", 16'(rdata), 16'h0);
    endtask

    task automatic t_basic;
        wr(4'd0, 8'h04); chk("R4 lo write sel", 16'(sel), 16'h0004);
        rd(4'd0); chk("R4 lo read", 16'(rdata), 16'h04);
        wr(4'd1, 8'h02); chk("R5 cross-register clear", 16'(sel), 16'h0);
        rd(4'd0); chk("R5 lo emptied", 16'(rdata), 16'h0);
        wr(4'd1, 8'h02); chk("R4 hi write block 9", 16'(sel), 16'h0200);
        rd(4'd1); chk("R4 hi read", 16'(rdata), 16'h02);
        wr(4'd1, 8'h04); chk("R4 hi replace", 16'(sel), 16'h0400);
        wr(4'd0, 8'h00); chk("R4 lo zero keeps hi", 16'(sel), 16'h0400);
        wr(4'd1, 8'h00); chk("R4 hi cleared", 16'(sel), 16'h0);
        wr(4'd0, 8'h01); chk("R4 block 0", 16'(sel), 16'h0001);
        wr(4'd0, 8'h03); chk("R5 two bits one write", 16'(sel), 16'h0);
        wr(4'd0, 8'h80); chk("R4 block 7", 16'(sel), 16'h0080);
        wr(4'd0, 8'h00);
    endtask

    task automatic t_reserved;
        wr(4'd1, 8'h20);
        chk("R7 block 13 on 14", 16'(sel), 16'h2000);
        chk("R7 block 13 dropped on 12", 16'(sel12), 16'h0);
        rd(4'd1);
        chk("R7 hi read 14", 16'(rdata), 16'h20);
        chk("R7 hi read 12", 16'(rdata12), 16'h00);
        wr(4'd1, 8'hC0);
        chk("R7 bits 7:6 dropped", 16'(sel), 16'h0);
        rd(4'd1); chk("R7 hi reads zero", 16'(rdata), 16'h0);
        wr(4'd1, 8'h18);
        chk("R5 two bits on 14", 16'(sel), 16'h0);
        chk("R7 mask before count on 12", 16'(sel12), 16'h0800);
        wr(4'd1, 8'h00);
    endtask

    task automatic t_flash_off;
        wr(4'd1, 8'h01); chk("R4 block 8", 16'(sel), 16'h0100);
        @(negedge clk); flash_en = 1'b0; #1;
        chk("R6 sel blanked", 16'(sel), 16'h0);
        rd(4'd1); chk("R6 read zero", 16'(rdata), 16'h0);
        wr(4'd0, 8'h10);
        flash_en = 1'b1; #1;
        chk("R6 selection kept", 16'(sel), 16'h0100);
        rd(4'd0); chk("R6 write ignored", 16'(rdata), 16'h0);
    endtask

    task automatic t_soft;
        @(negedge clk); swe_bit = 1'b0;
        @(negedge clk); chk("R3 hi bit0 cleared", 16'(sel), 16'h0);
        wr(4'd1, 8'h08); chk("R3 hi upper writable", 16'(sel), 16'h0800);
        wr(4'd0, 8'h02); chk("R3 lo held zero", 16'(sel), 16'h0800);
        wr(4'd1, 8'h01); chk("R3 hi bit0 held", 16'(sel), 16'h0);
        swe_bit = 1'b1;
        wr(4'd1, 8'h08);
        wr(4'd0, 8'h02); chk("R5 lo onto hi clears", 16'(sel), 16'h0);
        wr(4'd0, 8'h02); chk("R4 block 1", 16'(sel), 16'h0002);
        swe_bit = 1'b0;
        @(negedge clk); chk("R3 lo cleared", 16'(sel), 16'h0);
        swe_bit = 1'b1;
    endtask

    task automatic t_standby;
        wr(4'd0, 8'h40);
        hw_stby = 1'b1; @(negedge clk); hw_stby = 1'b0;
        chk("R2 hw standby", 16'(sel), 16'h0);
        wr(4'd0, 8'h40);
        sw_stby = 1'b1; @(negedge clk); sw_stby = 1'b0;
        chk("R2 sw standby", 16'(sel), 16'h0);
        wr(4'd0, 8'h40);
        hw_stby = 1'b1; wr(4'd0, 8'h20); hw_stby = 1'b0;
        chk("R2 standby beats write", 16'(sel), 16'h0);
        fwe_pin = 1'b0; wr(4'd0, 8'h80); fwe_pin = 1'b1;
        @(negedge clk);
        chk("R2 pin low beats write", 16'(sel), 16'h0);
    endtask

    task automatic t_unmapped;
        wr(4'd0, 8'h10);
        wr(4'd5, 8'hFF); chk("R8 unmapped write", 16'(sel), 16'h0010);
        rd(4'd5); chk("R8 unmapped read", 16'(rdata), 16'h0);
    endtask

    initial begin
        t_reset;
        t_basic;
        t_reserved;
        t_flash_off;
        t_soft;
        t_standby;
        t_unmapped;
        if (!done) begin
            done = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end
endmodule